// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the write side of a small on-chip parallel NOR flash model. The array is never written directly. Every bus write is read as one step of a multi-cycle command protocol, and the block tracks how far a command has progressed. A two-write unlock pair opens the command phase. A command byte then selects one of these operations: program, erase, identification, the query table, or a bypass mode. In bypass mode the unlock pair can be skipped for repeated commands.

Programming can only clear bits: the stored bytes are ANDed with the written data. An erase sets a whole sector or the whole chip to 0xFF. While an erase runs, a busy timer counts down, and every bus write is discarded until the timer expires. The block exposes three things to a read path: a byte read port into the storage array, a mode code that tells the read path what to return, and a status byte.

Top module: `nor_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, every byte of the array reads 0xFF, rd_mode is 0, status is 0x00, and busy and bypass are 0.
- R2: A command step compares only the word offset, which is (wr_addr mod SECTOR_BYTES) / PORT_BYTES. With the defaults (256-byte sectors, 2-byte port), the first unlock word 0x55 is byte 0xAA of any sector and the second unlock word 0x2A is byte 0x54.
- R3: A command opens with 0xAA written at the first unlock word, followed by 0x55 at the second unlock word. A wrong address or wrong data at either step returns the block to array read mode and clears bypass.
- R4: At the command step, the write must hit the first unlock word unless bypass is active. The command byte is then decoded: 0x20 enters bypass, 0x80 starts erase setup, 0x90 enters identification, and 0xA0 arms a program. Any other byte returns the block to read mode.
- R5: A write of 0xF0 returns the block to read mode and clears bypass. Two exceptions apply: while a program waits for its data, 0xF0 is taken as program data, and while an erase runs, 0xF0 is ignored like any other write.
- R6: The program data write ANDs each addressed byte with the written byte. wr_size 0, 1 and 2 cover 1, 2 and 4 bytes starting at wr_addr, and addresses wrap modulo the array size. When wr_big_end is 0, byte wr_addr+i takes data bits [8i+7:8i]. When wr_big_end is 1, the lane order is reversed.
- R7: After a program, status becomes {~data[7], 7'h7F}. The block then returns to the command step if bypass is active, or to read mode otherwise.
- R8: After erase setup, a second unlock pair must be written. Then 0x10 written at the first unlock word erases the chip, while 0x30 written at any address erases the sector that contains that address. Any other write returns the block to read mode. When an erase starts, status is set to 0x00 and busy is raised.
- R9: busy stays high for CHIP_ERASE_CYC cycles after a chip erase starts, or SECT_ERASE_CYC cycles after a sector erase starts. All writes are ignored during that time. When busy ends, status bit 7 is inverted, and the block returns to the command step if bypass is active, or to read mode otherwise.
- R10: Writing 0x98 at word offset 0x55 enters query mode. This works from read mode, from identification mode, and at the first step of the second unlock pair. Any write made in query mode returns the block to read mode.
- R11: In identification mode with bypass active, writing 0x00 clears bypass and returns the block to read mode.
- R12: rd_mode reports what the read path should return. 0 means array data: read mode, the unlock steps, the command step and the erase setup steps. 1 means identification. 2 means status: a program waiting for data, or an erase running. 3 means the query table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data; the command byte is bits [7:0] |
| wr_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wr_big_end | input | 1 | Lane order of the program data |
| rd_addr | input | ADDR_W | Byte address for the array read port |
| rd_byte | output | 8 | Array byte at rd_addr |
| rd_mode | output | 2 | Read path selector (see R12) |
| status | output | 8 | Status byte for polling |
| busy | output | 1 | An erase is running |
| bypass | output | 1 | Bypass mode is active |

## Verification
When the sequencer holds the wrong state, the visible fault usually comes one write later. rd_mode shows the wrong code on the next cycle, or the following command step is accepted or rejected in a way the reference model does not expect. The bench compares rd_mode, status, busy, bypass and the array byte under a moving read address against a behavioural model on every clock. A corrupt erase or lane mapping therefore shows up in the cycle after the write that caused it. A timer that is off by one shows up at the exact edge where busy falls.

// File: rtl/nor_seq_pkg.sv
// Shared encodings for the NOR command sequencer.
// Assumes: command bytes arrive in bits [7:0] of the write data.
package nor_seq_pkg;

    typedef enum logic [3:0] {
        ST_READ,     // array read mode
        ST_UNLK1,    // first unlock write seen
        ST_CMD,      // unlock pair done, command byte expected
        ST_PROG,     // program armed, data write expected
        ST_AUTOSEL,  // identification mode
        ST_EUNLK0,   // erase setup, second pair first write expected
        ST_EUNLK1,   // erase setup, second pair second write expected
        ST_ECMD,     // erase type expected
        ST_ERASING,  // erase running, writes ignored
        ST_CFI       // query table mode
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2,
        RM_QUERY  = 2'd3
    } rd_mode_t;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] OP_BYPASS   = 8'h20;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_CHIP     = 8'h10;
    localparam logic [7:0] OP_SECTOR   = 8'h30;
    localparam logic [7:0] OP_ABORT    = 8'hF0;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BYP_EXIT = 8'h00;

endpackage

// File: rtl/nor_erase_timer.sv
// Erase busy timer: loads one of two cycle counts and counts down to zero.
// Assumes: both counts are at least 1; a start is never issued while busy.
module nor_erase_timer #(
    parameter int CHIP_CYC = 40,
    parameter int SECT_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_chip,
    input  logic start_sect,
    output logic busy,
    output logic done
);
    localparam int MAX_CYC = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (start_chip) cnt_q <= CNT_W'(CHIP_CYC);
        else if (start_sect) cnt_q <= CNT_W'(SECT_CYC);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

    assert_timer_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_chip && !start_sect) |=> !busy);

endmodule

// File: rtl/nor_store.sv
// Byte array storage: AND-only program on up to four lanes, sector and chip erase.
// Assumes: the array is 2**ADDR_W bytes; program and erase never coincide.
module nor_store #(
    parameter int ADDR_W   = 10,
    parameter int SECTOR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [31:0]       prog_data,
    input  logic [1:0]        prog_size,
    input  logic              prog_be,
    input  logic              chip_ers,
    input  logic              sect_ers,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    localparam int BYTES     = 1 << ADDR_W;
    localparam int SEC_BYTES = 1 << SECTOR_W;
    localparam int LANES     = 4;

    logic [7:0]        mem_q     [BYTES];
    logic [ADDR_W-1:0] lane_addr [LANES];
    logic [7:0]        lane_val  [LANES];
    logic [LANES-1:0]  lane_on;
    logic [2:0]        nbytes;
    logic [7:0]        old_b0;

    // Number of bytes covered by the access size.
    always_comb begin
        case (prog_size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_addr[i] = prog_addr + ADDR_W'(i);
        assign lane_on[i]   = (3'(i) < nbytes);
        // Pick this lane's data byte according to the lane order.
        always_comb begin
            int sh;
            sh = prog_be ? 8 * (int'(nbytes) - 1 - i) : 8 * i;
            if (!lane_on[i]) sh = 0;
            lane_val[i] = 8'(prog_data >> sh);
        end
    end

    // Array update: reset and erase to 0xFF, program by AND.
    always_ff @(posedge clk) begin
        if (!rst_n || chip_ers) begin
            for (int j = 0; j < BYTES; j++) mem_q[j] <= 8'hFF;
        end else if (sect_ers) begin
            for (int j = 0; j < BYTES; j++)
                if ((j / SEC_BYTES) == int'(prog_addr[ADDR_W-1:SECTOR_W])) mem_q[j] <= 8'hFF;
        end else if (prog_en) begin
            for (int k = 0; k < LANES; k++)
                if (lane_on[k]) mem_q[lane_addr[k]] <= mem_q[lane_addr[k]] & lane_val[k];
        end
    end

    assign rd_byte = mem_q[rd_addr];
    assign old_b0  = mem_q[lane_addr[0]];

    assert_prog_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !chip_ers && !sect_ers) |=>
            ((mem_q[$past(lane_addr[0])] & ~$past(old_b0)) == 8'h00));

    assert_chip_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_ers |=> (mem_q[0] == 8'hFF && mem_q[BYTES-1] == 8'hFF));

endmodule

// File: rtl/nor_cmd_fsm.sv
// Command sequencer: decodes unlock pairs, commands, bypass and query entry,
// and owns the status byte.
// Assumes: one write per cycle; word_off is already reduced to the sector word offset.
module nor_cmd_fsm
    import nor_seq_pkg::*;
#(
    parameter int OFF_W     = 7,
    parameter int UNLOCK_A  = 'h55,
    parameter int UNLOCK_B  = 'h2A,
    parameter int QUERY_OFF = 'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] word_off,
    input  logic [7:0]       cmd,
    input  logic             erase_done,
    input  logic             tmr_busy,
    output logic             prog_en,
    output logic             chip_ers,
    output logic             sect_ers,
    output logic             bypass,
    output logic [7:0]       status,
    output rd_mode_t         rd_mode
);
    seq_state_t state_q, state_d;
    logic       byp_q, byp_d;
    logic [7:0] status_q, status_d;
    logic       at_a, at_b, at_q;

    assign at_a = (word_off == OFF_W'(UNLOCK_A));
    assign at_b = (word_off == OFF_W'(UNLOCK_B));
    assign at_q = (word_off == OFF_W'(QUERY_OFF));

    // Next-state decode of the command protocol.
    always_comb begin
        state_d  = state_q;
        byp_d    = byp_q;
        status_d = status_q;
        prog_en  = 1'b0;
        chip_ers = 1'b0;
        sect_ers = 1'b0;
        if (state_q == ST_ERASING) begin
            if (erase_done) begin
                status_d = status_q ^ 8'h80;
                state_d  = byp_q ? ST_CMD : ST_READ;
            end
        end else if (wr_en) begin
            if (cmd == OP_ABORT && state_q != ST_PROG) begin
                state_d = ST_READ;
                byp_d   = 1'b0;
            end else begin
                // Default outcome of any rejected write.
                state_d = ST_READ;
                byp_d   = 1'b0;
                case (state_q)
                    ST_READ, ST_EUNLK0: begin
                        if (at_q && cmd == OP_QUERY) begin
                            state_d = ST_CFI;
                            byp_d   = byp_q;
                        end else if (at_a && cmd == KEY_FIRST) begin
                            state_d = (state_q == ST_READ) ? ST_UNLK1 : ST_EUNLK1;
                            byp_d   = byp_q;
                        end
                    end
                    ST_UNLK1, ST_EUNLK1: begin
                        if (at_b && cmd == KEY_SECOND) begin
                            state_d = (state_q == ST_UNLK1) ? ST_CMD : ST_ECMD;
                            byp_d   = byp_q;
                        end
                    end
                    ST_CMD: begin
                        if (byp_q || at_a) begin
                            byp_d = byp_q;
                            case (cmd)
                                OP_BYPASS:  begin state_d = ST_CMD; byp_d = 1'b1; end
                                OP_ERASE:   state_d = ST_EUNLK0;
                                OP_IDENT:   state_d = ST_AUTOSEL;
                                OP_PROGRAM: state_d = ST_PROG;
                                default:    begin state_d = ST_READ; byp_d = 1'b0; end
                            endcase
                        end
                    end
                    ST_PROG: begin
                        prog_en  = 1'b1;
                        status_d = {~cmd[7], 7'h7F};
                        byp_d    = byp_q;
                        state_d  = byp_q ? ST_CMD : ST_READ;
                    end
                    ST_AUTOSEL: begin
                        if (!(byp_q && cmd == OP_BYP_EXIT) && at_q && cmd == OP_QUERY) begin
                            state_d = ST_CFI;
                            byp_d   = byp_q;
                        end
                    end
                    ST_ECMD: begin
                        if ((cmd == OP_CHIP && at_a) || cmd == OP_SECTOR) begin
                            chip_ers = (cmd == OP_CHIP);
                            sect_ers = (cmd == OP_SECTOR);
                            status_d = 8'h00;
                            byp_d    = byp_q;
                            state_d  = ST_ERASING;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // State, bypass flag and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_READ;
            byp_q    <= 1'b0;
            status_q <= 8'h00;
        end else begin
            state_q  <= state_d;
            byp_q    <= byp_d;
            status_q <= status_d;
        end
    end

    // Read path selector from the current state.
    always_comb begin
        case (state_q)
            ST_AUTOSEL:          rd_mode = RM_IDENT;
            ST_PROG, ST_ERASING: rd_mode = RM_STATUS;
            ST_CFI:              rd_mode = RM_QUERY;
            default:             rd_mode = RM_ARRAY;
        endcase
    end

    assign bypass = byp_q;
    assign status = status_q;

    assert_read_no_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> !byp_q);

    assert_busy_erasing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> (state_q == ST_ERASING));

    assert_done_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> (status_q[7] != $past(status_q[7])));

    assert_erase_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_ers || sect_ers) |=> (status_q == 8'h00 && tmr_busy));

    assert_cfi_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CFI && wr_en) |=> (state_q == ST_READ));

    assert_prog_leave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && wr_en) |=> (state_q == ST_READ || state_q == ST_CMD));

endmodule

// File: rtl/nor_cmd_seq.sv
// Top of the NOR command sequencer: derives the sector word offset from the
// write address and joins the sequencer, erase timer and byte array.
// Assumes: PORT_BYTES is 1, 2 or 4 and the sector holds at least PORT_BYTES*128 bytes.
module nor_cmd_seq #(
    parameter int ADDR_W         = 10,
    parameter int SECTOR_W       = 8,
    parameter int PORT_BYTES     = 2,
    parameter int UNLOCK_A       = 'h55,
    parameter int UNLOCK_B       = 'h2A,
    parameter int CHIP_ERASE_CYC = 40,
    parameter int SECT_ERASE_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        wr_size,
    input  logic              wr_big_end,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    output logic [1:0]        rd_mode,
    output logic [7:0]        status,
    output logic              busy,
    output logic              bypass
);
    import nor_seq_pkg::*;

    localparam int PB_SH = (PORT_BYTES == 4) ? 2 : (PORT_BYTES == 2) ? 1 : 0;
    localparam int OFF_W = SECTOR_W - PB_SH;

    logic [OFF_W-1:0] word_off;
    logic             prog_en, chip_ers, sect_ers, erase_done;
    rd_mode_t         mode_w;

    assign word_off = wr_addr[SECTOR_W-1:PB_SH];

    nor_cmd_fsm #(
        .OFF_W(OFF_W), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B), .QUERY_OFF('h55)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_off(word_off),
        .cmd(wr_data[7:0]), .erase_done(erase_done), .tmr_busy(busy),
        .prog_en(prog_en), .chip_ers(chip_ers), .sect_ers(sect_ers),
        .bypass(bypass), .status(status), .rd_mode(mode_w)
    );

    nor_erase_timer #(
        .CHIP_CYC(CHIP_ERASE_CYC), .SECT_CYC(SECT_ERASE_CYC)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_chip(chip_ers), .start_sect(sect_ers),
        .busy(busy), .done(erase_done)
    );

    nor_store #(
        .ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_addr(wr_addr),
        .prog_data(wr_data), .prog_size(wr_size), .prog_be(wr_big_end),
        .chip_ers(chip_ers), .sect_ers(sect_ers), .rd_addr(rd_addr), .rd_byte(rd_byte)
    );

    assign rd_mode = mode_w;

endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
    localparam int CLK_P = 10;
    localparam int AW    = 10;
    localparam int NB    = 1 << AW;
    localparam int CHIPC = 40;
    localparam int SECTC = 12;
    localparam int UA_B  = 'hAA;   // byte address of unlock word 0x55
    localparam int UB_B  = 'h54;   // byte address of unlock word 0x2A

    logic          clk = 0, rst_n = 0, wr_en = 0, wr_big_end = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    wr_size = '0;
    logic [7:0]    rd_byte, status;
    logic [1:0]    rd_mode;
    logic          busy, bypass;

    nor_cmd_seq #(.CHIP_ERASE_CYC(CHIPC), .SECT_ERASE_CYC(SECTC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_size(wr_size), .wr_big_end(wr_big_end), .rd_addr(rd_addr), .rd_byte(rd_byte),
        .rd_mode(rd_mode), .status(status), .busy(busy), .bypass(bypass)
    );

    always #(CLK_P/2) clk = ~clk;

    int    vectors = 0, miscompares = 0;
    bit    cmp_on = 0;
    string cur_req = "R1";

    // Behavioural reference: write-cycle number plus latched command byte.
    byte unsigned m_mem [NB];
    int  m_cyc, m_cmd, m_byp, m_stat, m_tmr;

    function automatic void m_abort();
        m_cyc = 0; m_cmd = 0; m_byp = 0;
    endfunction

    function automatic void m_write(int a, logic [31:0] d, int sz, bit be);
        int c, off, n;
        c = d[7:0];
        off = (a % 256) / 2;
        if (c == 'hF0 && !(m_cyc == 3 && m_cmd == 'hA0)) begin m_abort(); return; end
        case (m_cyc)
            0: if (off == 'h55 && c == 'h98) begin m_cyc = 7; m_cmd = 'h98; end
               else if (off == 'h55 && c == 'hAA) m_cyc = 1;
               else m_abort();
            1: if (off == 'h2A && c == 'h55) m_cyc = 2; else m_abort();
            2: if (m_byp == 0 && off != 'h55) m_abort();
               else if (c == 'h20) begin m_byp = 1; m_cyc = 2; m_cmd = 0; end
               else if (c == 'h80 || c == 'h90 || c == 'hA0) begin m_cmd = c; m_cyc = 3; end
               else m_abort();
            3: if (m_cmd == 'h80) begin
                   if (off == 'h55 && c == 'h98) begin m_cyc = 7; m_cmd = 'h98; end
                   else if (off == 'h55 && c == 'hAA) m_cyc = 4;
                   else m_abort();
               end else if (m_cmd == 'hA0) begin
                   n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
                   for (int i = 0; i < n; i++) begin
                       logic [31:0] v;
                       v = be ? (d >> (8 * (n - 1 - i))) : (d >> (8 * i));
                       m_mem[(a + i) % NB] &= v[7:0];
                   end
                   m_stat = d[7] ? 'h7F : 'hFF;
                   if (m_byp != 0) begin m_cyc = 2; m_cmd = 0; end else m_abort();
               end else begin
                   if (m_byp != 0 && c == 0) m_abort();
                   else if (off == 'h55 && c == 'h98) begin m_cyc = 7; m_cmd = 'h98; end
                   else m_abort();
               end
            4: if (off == 'h2A && c == 'h55) m_cyc = 5; else m_abort();
            5: if (c == 'h10 && off == 'h55) begin
                   for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
                   m_stat = 0; m_tmr = CHIPC; m_cmd = 'h10; m_cyc = 6;
               end else if (c == 'h30) begin
                   for (int i = 0; i < 256; i++) m_mem[(a / 256) * 256 + i] = 8'hFF;
                   m_stat = 0; m_tmr = SECTC; m_cmd = 'h30; m_cyc = 6;
               end else m_abort();
            default: m_abort();
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
            m_abort(); m_stat = 0; m_tmr = 0;
        end else if (m_cyc == 6) begin
            if (m_tmr > 0) begin
                m_tmr--;
                if (m_tmr == 0) begin
                    m_stat ^= 'h80; m_cmd = 0;
                    m_cyc = (m_byp != 0) ? 2 : 0;
                end
            end
        end else if (wr_en) m_write(int'(wr_addr), wr_data, int'(wr_size), wr_big_end);
    end

    function automatic int m_mode();
        case (m_cmd)
            'h90: return 1;
            'hA0, 'h10, 'h30: return 2;
            'h98: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string what, int got, int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, got, exp);
        end
    endtask

    // Compare every cycle, a quarter period after the falling edge.
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (cmp_on) begin
            chk("rd_mode", int'(rd_mode), m_mode());
            chk("status",  int'(status), m_stat);
            chk("busy",    int'(busy), (m_cyc == 6 && m_tmr > 0) ? 1 : 0);
            chk("bypass",  int'(bypass), m_byp);
            chk("rd_byte", int'(rd_byte), int'(m_mem[rd_addr]));
        end
    end

    task automatic wr(int a, logic [31:0] d, int sz = 0, bit be = 0);
        @(negedge clk);
        wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_size = 2'(sz); wr_big_end = be;
        rd_addr = AW'(a);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(int n, int ra = -1);
        if (ra >= 0) rd_addr = AW'(ra);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock(int base = 0);
        wr(base + UA_B, 'hAA);
        wr(base + UB_B, 'h55);
    endtask

    initial begin
        #(CLK_P * 200000);
        miscompares++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;
        // R1: reset state across several sectors
        cur_req = "R1";
        for (int i = 0; i < 8; i++) idle(1, i * 131);

        // R2, R6, R7: program through an unlock issued in sector 1, LE halfword
        cur_req = "R2";
        unlock('h100); wr('h1AA, 'hA0);
        cur_req = "R5";  // 0xF0 as program data is not an abort
        wr('h100, 'h12F0, 1, 0);
        idle(2, 'h101);
        cur_req = "R6";
        unlock(); wr(UA_B, 'hA0); wr('h100, 'h0F3C, 1, 0);
        idle(2, 'h100);
        cur_req = "R6";  // big-endian word, wrapping across the top of the array
        unlock(); wr(UA_B, 'hA0); wr('h3FE, 'h11223344, 2, 1);
        idle(1, 'h3FF); idle(1, 'h000); idle(1, 'h001);
        cur_req = "R7";
        unlock(); wr(UA_B, 'hA0); wr('h205, 'h85, 0, 0);
        idle(2, 'h205);

        // R2: byte 0x55 is word 0x2A, not the first unlock word
        cur_req = "R2";
        wr('h55, 'hAA); idle(1);
        // R3: wrong data at the second step, wrong address at the second step
        cur_req = "R3";
        wr(UA_B, 'hAA); wr(UB_B, 'h56); idle(1);
        wr(UA_B, 'hAA); wr(UA_B, 'h55); idle(1);
        // R4: unknown command, command at the wrong address, identification
        cur_req = "R4";
        unlock(); wr(UA_B, 'h77); idle(1);
        unlock(); wr(UB_B, 'h90); idle(1);
        unlock(); wr(UA_B, 'h90); idle(2);
        // R10: query from identification, then any write leaves
        cur_req = "R10";
        wr(UA_B, 'h98); idle(2); wr('h10, 'h12); idle(1);
        wr(UA_B, 'h98); idle(1); wr(UA_B, 'hF0); idle(1);
        unlock(); wr(UA_B, 'h80); wr(UA_B, 'h98); idle(1); wr(0, 0); idle(1);
        // R5: abort in the middle of an unlock
        cur_req = "R5";
        wr(UA_B, 'hAA); wr(UB_B, 'hF0); idle(1);
        unlock(); wr(UA_B, 'h80); wr(UA_B, 'hF0); idle(1);

        // R8, R9: sector erase of sector 1, writes ignored while busy
        cur_req = "R8";
        unlock(); wr(UA_B, 'h80); unlock(); wr('h1C3, 'h30);
        cur_req = "R9";
        wr(UA_B, 'hF0); wr(UA_B, 'hAA); idle(SECTC + 3, 'h100);
        idle(1, 'h000);
        // R8: chip erase at the wrong address is rejected, at the right one erases all
        cur_req = "R8";
        unlock(); wr(UA_B, 'h80); unlock(); wr(UB_B, 'h10); idle(1);
        unlock(); wr(UA_B, 'h80); unlock(); wr(UA_B, 'h10);
        cur_req = "R9";
        idle(CHIPC + 2, 'h205); idle(1, 'h3FF);

        // R4, R7: bypass with short program sequences at any address
        cur_req = "R4";
        unlock(); wr(UA_B, 'h20); idle(1);
        cur_req = "R7";
        wr('h033, 'hA0); wr('h300, 'h5A, 0, 0); idle(1, 'h300);
        wr('h077, 'hA0); wr('h301, 'hC3A5, 1, 1); idle(1, 'h302);
        // R9: sector erase inside bypass returns to the command step
        cur_req = "R9";
        wr(UA_B, 'h80); unlock(); wr('h310, 'h30); idle(SECTC + 2, 'h300);
        // R12: mode code across bypass steps
        cur_req = "R12";
        wr('h001, 'hA0); idle(1); wr('h301, 'h0F, 0, 0); idle(1);
        // R11: exit bypass from identification
        cur_req = "R11";
        wr('h001, 'h90); idle(1); wr('h000, 'h00); idle(2);
        // R5: abort in bypass clears it
        unlock(); wr(UA_B, 'h20); cur_req = "R5"; wr('h0, 'hF0); idle(2);
        // R10: query straight from read mode
        cur_req = "R10";
        wr(UA_B, 'h98); idle(1); wr('h7, 'h55); idle(1);

        cmp_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule